// File: doc/BRIEF.md
# Bi/Tri-Level Sync and Blank Inserter

This block sits at the end of a three-channel video pixel pipeline, just ahead of the DAC codes. On every clock it picks one of three things for each channel: the incoming pixel code, that channel's blanking code, or a sync request. A sync request is the blanking code plus a flag that tells the analog side to add a negative or a positive sync current. The inputs are an active-low sync strobe, an active-high tri-level select that times the positive half of a tri-level pulse, and an active-low blank strobe. The block registers all three on the clock.

Two static settings shape the output. The first is a flag that spreads sync onto all three channels instead of only the luma/green channel. The second is the colour mode. The control strobes go through a delay line whose tap depends on the mode, so each control meets the pixel it belongs to in the same output cycle. A design parameter picks the device variant whose chroma blanking level is always mid-scale.

Top module: `sync_blank_inserter`

## Requirements
- R1: The block registers sync_n, tri_sel and blank_n on the rising clock edge and registers pix_i once. The output after edge n combines pix_i sampled at edge n with the controls sampled at edge n-d-1. The value of d depends on mode: 0 for mode 0 (RGB 4:4:4) and mode 1 (YCbCr 4:4:4), 1 for mode 2 (4:2:2 two-port) and 2 for mode 3 (4:2:2 one-port).
- R2: While the delayed sync is asserted (low), each channel selected for sync outputs its blanking code, whatever the pixel data or blank.
- R3: During sync on a selected channel, neg_en_o is high when the delayed tri_sel is low and pos_en_o is high when it is high. The two flags are never high together.
- R4: While the delayed sync is not asserted, tri_sel has no effect: both enable flags stay low and the code follows blank and the data.
- R5: With ins_all low only channel 1 (G/Y) is selected for sync. With ins_all high all three channels (0 = R/Pr, 1 = G/Y, 2 = B/Pb) are selected.
- R6: When blank is asserted (low) and sync is not, all three channels output their blanking codes and both flags stay low.
- R7: The blanking code of channel 1 is always 0.
- R8: The blanking code of channels 0 and 2 is 2^(W-1) (128 for W = 8) when ins_all is high or the MID_CHROMA parameter is 1. Otherwise it is 0.
- R9: A channel that is not selected for sync outputs its blanking code with both flags low during a sync interval.
- R10: With neither sync nor blank asserted, each channel outputs its pixel code unchanged.
- R11: After reset, every code output and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Sync strobe, active low |
| tri_sel | input | 1 | Positive-half select for tri-level sync, active high |
| blank_n | input | 1 | Blank strobe, active low |
| ins_all | input | 1 | Put sync on all three channels when high |
| mode | input | 2 | Colour mode, sets the control delay |
| pix_i | input | 3*W | Pixel codes, channel c in bits [c*W +: W] |
| code_o | output | 3*W | DAC codes, channel c in bits [c*W +: W] |
| neg_en_o | output | 3 | Negative sync current enable per channel |
| pos_en_o | output | 3 | Positive sync current enable per channel |

## Verification
The assertions check on every cycle that the two sync flags of a channel are never high together, and that a flag never appears on an unselected chroma channel while ins_all is low. They also check that a channel raising a flag carries its blanking code, and that with all-channel insertion the three channels raise the same flag. Only the bench's scenarios can show the mode-dependent control alignment, the override of data by blank, the pass-through of data, and the variant-dependent chroma blanking level. For these the bench sweeps a pseudo-random control and data stream through every mode and insertion setting on two instances, one of each variant, and predicts each output cycle from its history.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

    typedef enum logic [1:0] {
        MODE_RGB444     = 2'd0,
        MODE_YCC444     = 2'd1,
        MODE_YCC422_TWO = 2'd2,
        MODE_YCC422_ONE = 2'd3
    } vmode_e;

    // Control strobes converted to active-high form.
    typedef struct packed {
        logic sync;
        logic tri_hi;
        logic blank;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{sync: 1'b0, tri_hi: 1'b0, blank: 1'b0};

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic ctl_t decode_ctl(logic sync_n, logic tri_sel, logic blank_n);
        ctl_t r;
        r.sync   = ~sync_n;
        r.tri_hi = tri_sel;
        r.blank  = ~blank_n;
        return r;
    endfunction

endpackage

// File: rtl/sbi_ctl_delay.sv
module sbi_ctl_delay
    import sbi_pkg::*;
#(
    parameter int unsigned MAXD = 2,
    parameter int unsigned SELW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  ctl_t            ctl_i,
    input  logic [SELW-1:0] sel_i,
    output ctl_t            ctl_o
);

    ctl_t stage [0:MAXD];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= CTL_IDLE;
        else     stage[0] <= ctl_i;
    end

    generate
        for (genvar i = 1; i <= MAXD; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= CTL_IDLE;
                else     stage[i] <= stage[i-1];
            end
        end
    endgenerate

    always_comb begin
        if (int'(sel_i) > MAXD) ctl_o = stage[MAXD];
        else                    ctl_o = stage[sel_i];
    end

endmodule

// File: rtl/sbi_chan_mux.sv
module sbi_chan_mux
    import sbi_pkg::*;
#(
    parameter int unsigned W          = 8,
    parameter bit          IS_LUMA    = 1'b0,
    parameter bit          MID_CHROMA = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl_i,
    input  logic         ins_all,
    input  logic [W-1:0] pix_i,
    output logic [W-1:0] code_o,
    output logic         neg_o,
    output logic         pos_o
);

    localparam logic [W-1:0] MID_CODE = W'(1) << (W - 1);

    logic [W-1:0] blank_code;
    logic         selected;

    always_comb begin
        if (IS_LUMA)                     blank_code = '0;
        else if (ins_all || MID_CHROMA)  blank_code = MID_CODE;
        else                             blank_code = '0;
        selected = IS_LUMA || ins_all;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= '0;
            neg_o  <= 1'b0;
            pos_o  <= 1'b0;
        end else if (ctl_i.sync) begin
            code_o <= blank_code;
            neg_o  <= selected && !ctl_i.tri_hi;
            pos_o  <= selected &&  ctl_i.tri_hi;
        end else begin
            code_o <= ctl_i.blank ? blank_code : pix_i;
            neg_o  <= 1'b0;
            pos_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/sync_blank_inserter.sv
module sync_blank_inserter
    import sbi_pkg::*;
#(
    parameter int unsigned W          = 8,
    parameter int unsigned DLY_FULL   = 0,
    parameter int unsigned DLY_TWO    = 1,
    parameter int unsigned DLY_ONE    = 2,
    parameter bit          MID_CHROMA = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sync_n,
    input  logic           tri_sel,
    input  logic           blank_n,
    input  logic           ins_all,
    input  logic [1:0]     mode,
    input  logic [3*W-1:0] pix_i,
    output logic [3*W-1:0] code_o,
    output logic [2:0]     neg_en_o,
    output logic [2:0]     pos_en_o
);

    localparam int unsigned MAXD = max3(DLY_FULL, DLY_TWO, DLY_ONE);
    localparam int unsigned SELW = (MAXD > 0) ? $clog2(MAXD + 1) : 1;
    localparam int unsigned NCH  = 3;
    localparam int unsigned LUMA = 1;

    ctl_t            ctl_now;
    ctl_t            ctl_dly;
    logic [SELW-1:0] tap;

    assign ctl_now = decode_ctl(sync_n, tri_sel, blank_n);

    always_comb begin
        case (vmode_e'(mode))
            MODE_YCC422_TWO: tap = SELW'(DLY_TWO);
            MODE_YCC422_ONE: tap = SELW'(DLY_ONE);
            default:         tap = SELW'(DLY_FULL);
        endcase
    end

    sbi_ctl_delay #(.MAXD(MAXD), .SELW(SELW)) u_dly (
        .clk   (clk),
        .rst   (rst),
        .ctl_i (ctl_now),
        .sel_i (tap),
        .ctl_o (ctl_dly)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            sbi_chan_mux #(
                .W          (W),
                .IS_LUMA    (c == LUMA),
                .MID_CHROMA (MID_CHROMA)
            ) u_mux (
                .clk     (clk),
                .rst     (rst),
                .ctl_i   (ctl_dly),
                .ins_all (ins_all),
                .pix_i   (pix_i[c*W +: W]),
                .code_o  (code_o[c*W +: W]),
                .neg_o   (neg_en_o[c]),
                .pos_o   (pos_en_o[c])
            );
        end
    endgenerate

endmodule

// File: rtl/sbi_checker.sv
module sbi_checker #(
    parameter int unsigned W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           ins_all,
    input logic [3*W-1:0] code_o,
    input logic [2:0]     neg_en_o,
    input logic [2:0]     pos_en_o
);

    localparam logic [W-1:0] MID_CODE = W'(1) << (W - 1);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (neg_en_o & pos_en_o) == 3'b000);                                    // R3

    AST_LUMA_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$past(ins_all) |-> (neg_en_o[0] | pos_en_o[0] | neg_en_o[2] | pos_en_o[2]) == 1'b0); // R5

    AST_LUMA_SYNC_CODE: assert property (@(posedge clk) disable iff (rst)
        (neg_en_o[1] || pos_en_o[1]) |-> code_o[W +: W] == '0);              // R2

    AST_CHROMA_SYNC_CODE: assert property (@(posedge clk) disable iff (rst)
        (neg_en_o[0] || pos_en_o[2]) |-> (code_o[0 +: W] == MID_CODE && code_o[2*W +: W] == MID_CODE)); // R8

    AST_ALL_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        $past(ins_all) |-> (neg_en_o == 3'b000 || neg_en_o == 3'b111)
                        && (pos_en_o == 3'b000 || pos_en_o == 3'b111));      // R5

    AST_ONE_POLARITY: assert property (@(posedge clk) disable iff (rst)
        $onehot0({|neg_en_o, |pos_en_o}));                                    // R3

endmodule

bind sync_blank_inserter sbi_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ins_all  (ins_all),
    .code_o   (code_o),
    .neg_en_o (neg_en_o),
    .pos_en_o (pos_en_o)
);

// File: tb/sim_sync_blank_inserter.sv
module sim_sync_blank_inserter;

    localparam int unsigned W      = 8;
    localparam time         PERIOD = 10ns;
    localparam int unsigned SEGLEN = 40;

    logic           clk = 1'b0;
    logic           rst;
    logic           sync_n, tri_sel, blank_n, ins_all;
    logic [1:0]     mode;
    logic [3*W-1:0] pix;
    logic [3*W-1:0] code0, code1;
    logic [2:0]     neg0, pos0, neg1, pos1;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    sync_blank_inserter #(.W(W), .MID_CHROMA(1'b0)) u0 (
        .clk(clk), .rst(rst), .sync_n(sync_n), .tri_sel(tri_sel), .blank_n(blank_n),
        .ins_all(ins_all), .mode(mode), .pix_i(pix),
        .code_o(code0), .neg_en_o(neg0), .pos_en_o(pos0)
    );

    sync_blank_inserter #(.W(W), .MID_CHROMA(1'b1)) u1 (
        .clk(clk), .rst(rst), .sync_n(sync_n), .tri_sel(tri_sel), .blank_n(blank_n),
        .ins_all(ins_all), .mode(mode), .pix_i(pix),
        .code_o(code1), .neg_en_o(neg1), .pos_en_o(pos1)
    );

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] bcode(int c, bit ins, bit midv);
        if (c == 1) return '0;                                 // R7
        return (ins || midv) ? (W'(1) << (W - 1)) : '0;        // R8
    endfunction

    bit             hs [8];
    bit             ht [8];
    bit             hb [8];
    logic [3*W-1:0] hd [8];
    logic [15:0]    lfsr = 16'hACE1;

    task automatic check_cycle(int k, int j, bit ins);
        for (int v = 0; v < 2; v++) begin
            for (int c = 0; c < 3; c++) begin
                logic [W-1:0] ecode;
                bit           en, ep, sel;
                string        tag;
                logic [W-1:0] acode;
                bit           an, ap;
                sel = (c == 1) || ins;
                en = 0; ep = 0;
                if (hs[k]) begin
                    ecode = bcode(c, ins, v == 1);
                    if (sel) begin
                        en = !ht[k]; ep = ht[k];
                        tag = ht[k] ? "R1/R3/R2" : "R1/R3/R2";
                    end else tag = "R1/R5/R9";
                end else if (hb[k]) begin
                    ecode = bcode(c, ins, v == 1);
                    tag = (c == 1) ? "R1/R6/R7" : "R1/R6/R8";
                end else begin
                    ecode = hd[j][c*W +: W];
                    tag = ht[k] ? "R1/R4/R10" : "R1/R10";
                end
                acode = (v == 0) ? code0[c*W +: W] : code1[c*W +: W];
                an    = (v == 0) ? neg0[c] : neg1[c];
                ap    = (v == 0) ? pos0[c] : pos1[c];
                chk(tag, $sformatf("inst%0d ch%0d code", v, c), acode, ecode);
                chk(tag, $sformatf("inst%0d ch%0d neg", v, c), an, en);
                chk(tag, $sformatf("inst%0d ch%0d pos", v, c), ap, ep);
            end
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; sync_n = 1'b0; tri_sel = 1'b1; blank_n = 1'b0;
        ins_all = 1'b1; mode = 2'd0; pix = '1;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "code u0", code0, 0);
        chk("R11", "code u1", code1, 0);
        chk("R11", "flags u0", {neg0, pos0}, 0);
        chk("R11", "flags u1", {neg1, pos1}, 0);
        rst = 1'b0;

        for (int m = 0; m < 4; m++) begin
            for (int ins = 0; ins < 2; ins++) begin
                int d;
                d = (m == 2) ? 1 : (m == 3) ? 2 : 0;
                mode = m[1:0];
                ins_all = ins[0];
                for (int n = 0; n < SEGLEN; n++) begin
                    int idx;
                    idx = n % 8;
                    hs[idx] = (lfsr[2:1] != 2'b11);
                    ht[idx] = lfsr[3];
                    hb[idx] = lfsr[4];
                    hd[idx] = {lfsr[15:8], lfsr[7:0] ^ 8'(n), lfsr[11:4]};
                    sync_n  = !hs[idx];
                    tri_sel = ht[idx];
                    blank_n = !hb[idx];
                    pix     = hd[idx];
                    @(posedge clk);
                    #1;
                    if (n >= 4) check_cycle((n - d - 1) % 8, idx, ins[0]);
                    for (int s = 0; s < 5; s++)
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule